// File: doc/BRIEF.md
# Physical Register Scoreboard with Consumer Wakeup

This block tracks, for every physical register of an out-of-order core, whether its value has been produced. It also keeps a small table of consumers that are still waiting on a register. When an instruction is inserted, the block reads each source against the scoreboard. A source that is already available, or that lies outside the tracked range, counts as ready at once. Any other source becomes a waiter record that holds the consumer tag, the register index and the source slot. The destination register of the inserted instruction is marked not ready, because a result is now in flight for it.

When a completion names a destination register, the block sets that register's ready bit. It then walks the waiter table and emits one wakeup event per cycle, each giving a consumer tag and the slot that became ready. While this drain runs, `busy_o` is high and no further completion is accepted. A per-tag count of outstanding slots lets the block flag the wakeup that makes a consumer issue-ready. A consumer whose sources are all ready at insert instead gets a ready pulse one cycle after insert. A squash by tag removes that consumer's waiter records.

The control is a two-state machine. `SB_IDLE` waits for a completion. The transition `SB_IDLE -> SB_DRAIN` fires on an accepted in-range completion. `SB_DRAIN -> SB_DRAIN` holds while a matching waiter remains, emitting one wakeup per cycle. `SB_DRAIN -> SB_IDLE` fires in the first cycle with no matching waiter left.

Top module: `wakeup_scoreboard`

## Requirements
- R1: After reset every physical register reads as not ready, and `busy_o`, `wk_valid_o`, `ins_rdy_o` and `err_o` are low.
- R2: An insert whose destination index is below NUM_PREGS clears that register's ready bit, so a later consumer of it waits.
- R3: An insert whose in-range destination still has waiter records raises `err_o` for one cycle, in the cycle after the insert.
- R4: A source presented not ready whose ready bit is already set counts as ready at once and leaves no waiter record, so a later completion of that register produces no wakeup for it.
- R5: A source presented not ready whose ready bit is clear becomes a waiter record. Its wakeup carries the consumer tag and the slot, where 0 means source 0 and 1 means source 1.
- R6: Indices greater than or equal to NUM_PREGS are never tracked. As a source such an index counts as ready. As a destination it clears nothing. As a completion it is dropped, leaving `busy_o` low and producing no wakeup.
- R7: A completion wakes every waiter on its register, one per cycle, from the lowest table entry up. It then empties that register's list and sets its ready bit.
- R8: `busy_o` rises in the cycle after an accepted completion and stays high for the waiter count plus one cycle. A completion presented while `busy_o` is high is not taken and must be held until it is.
- R9: A squash by tag removes every waiter record of that tag, so a later completion of the register it waited on produces no wakeup for that tag.
- R10: `ins_rdy_o` pulses with `ins_rdy_tag_o` one cycle after an insert that leaves no waiter. `wk_last_o` is set on the wakeup that readies a consumer's last waiting slot.
- R11: An insert whose source names the register being completed in the same cycle still gets that source woken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid_i | input | 1 | Insert strobe |
| ins_tag_i | input | TAG_W | Consumer tag of the inserted instruction |
| ins_src0_i | input | IDX_W | Source 0 register index |
| ins_src0_rdy_i | input | 1 | Source 0 already known ready |
| ins_src1_i | input | IDX_W | Source 1 register index |
| ins_src1_rdy_i | input | 1 | Source 1 already known ready |
| ins_dst_i | input | IDX_W | Destination register index (out of range means none) |
| cmp_valid_i | input | 1 | Completion strobe |
| cmp_dst_i | input | IDX_W | Completed destination register index |
| sq_valid_i | input | 1 | Squash strobe |
| sq_tag_i | input | TAG_W | Tag whose waiter records are removed |
| busy_o | output | 1 | Drain in progress; completions not taken |
| wk_valid_o | output | 1 | Wakeup event valid |
| wk_tag_o | output | TAG_W | Tag of the woken consumer |
| wk_slot_o | output | 1 | Slot that became ready |
| wk_last_o | output | 1 | This wakeup made the consumer issue-ready |
| ins_rdy_o | output | 1 | Consumer ready at insert |
| ins_rdy_tag_o | output | TAG_W | Tag for `ins_rdy_o` |
| err_o | output | 1 | Producer inserted over pending waiters |

## Verification
A table of inserts taken from reset mixes sources that are out of range, at the range boundary, flagged ready, not ready, and the same register named in both slots. Whether a ready pulse follows each insert shows whether the scoreboard read and the range test combine correctly. Completions are then aimed at registers with zero, one and two waiters, and at registers whose waiters were squashed. The wakeup order, slots, last flags and busy length separate a correct drain from one that skips, repeats or reorders records. A completion held across a busy window, an insert racing a completion of its own source, and producer inserts over live waiters cover the timing corners.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic {
        SB_IDLE  = 1'b0,
        SB_DRAIN = 1'b1
    } sb_state_e;
endpackage

// File: rtl/sb_ready_bits.sv
// One ready bit per physical register, with two read ports that treat
// untracked indices as ready.
module sb_ready_bits #(
    parameter int NUM_PREGS = 16,
    parameter int IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic             rd0,
    output logic             rd1
);
    logic [NUM_PREGS-1:0] rdy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '0;
        end else begin
            for (int g = 0; g < NUM_PREGS; g++) begin
                if (clr_en && clr_idx == IDX_W'(g))
                    rdy_q[g] <= 1'b0;
                else if (set_en && set_idx == IDX_W'(g))
                    rdy_q[g] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd0 = 1'b1;
        rd1 = 1'b1;
        for (int g = 0; g < NUM_PREGS; g++) begin
            if (rd0_idx == IDX_W'(g)) rd0 = rdy_q[g];
            if (rd1_idx == IDX_W'(g)) rd1 = rdy_q[g];
        end
    end
endmodule

// File: rtl/sb_waiter_table.sv
// Table of waiter records: allocation of up to two per insert, lowest-entry
// match for draining, kill by tag, release of one entry per cycle.
module sb_waiter_table #(
    parameter int NUM_WAIT = 8,
    parameter int IDX_W    = 5,
    parameter int TAG_W    = 3,
    localparam int PTR_W   = (NUM_WAIT > 1) ? $clog2(NUM_WAIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add0_en,
    input  logic             add1_en,
    input  logic [TAG_W-1:0] add_tag,
    input  logic [IDX_W-1:0] add0_reg,
    input  logic [IDX_W-1:0] add1_reg,
    input  logic             kill_en,
    input  logic [TAG_W-1:0] kill_tag,
    input  logic             rel_en,
    input  logic [PTR_W-1:0] rel_ptr,
    input  logic [IDX_W-1:0] look_reg,
    input  logic [IDX_W-1:0] chk_reg,
    output logic             hit_any,
    output logic [PTR_W-1:0] hit_ptr,
    output logic [TAG_W-1:0] hit_tag,
    output logic             hit_slot,
    output logic             chk_hit
);
    logic [NUM_WAIT-1:0] vld_q;
    logic [TAG_W-1:0]    tag_q  [NUM_WAIT];
    logic [IDX_W-1:0]    reg_q  [NUM_WAIT];
    logic [NUM_WAIT-1:0] slot_q;

    logic             free0_ok, free1_ok, b_ok;
    logic [PTR_W-1:0] free0, free1, b_ptr;

    always_comb begin
        free0_ok = 1'b0;
        free1_ok = 1'b0;
        free0    = '0;
        free1    = '0;
        for (int i = 0; i < NUM_WAIT; i++) begin
            if (!vld_q[i]) begin
                if (!free0_ok) begin
                    free0_ok = 1'b1;
                    free0    = PTR_W'(i);
                end else if (!free1_ok) begin
                    free1_ok = 1'b1;
                    free1    = PTR_W'(i);
                end
            end
        end
        b_ptr = add0_en ? free1 : free0;
        b_ok  = add0_en ? free1_ok : free0_ok;
    end

    always_comb begin
        hit_any = 1'b0;
        hit_ptr = '0;
        chk_hit = 1'b0;
        for (int i = NUM_WAIT - 1; i >= 0; i--) begin
            if (vld_q[i] && reg_q[i] == look_reg &&
                !(kill_en && tag_q[i] == kill_tag)) begin
                hit_any = 1'b1;
                hit_ptr = PTR_W'(i);
            end
            if (vld_q[i] && reg_q[i] == chk_reg)
                chk_hit = 1'b1;
        end
        hit_tag  = tag_q[hit_ptr];
        hit_slot = slot_q[hit_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            slot_q <= '0;
            for (int i = 0; i < NUM_WAIT; i++) begin
                tag_q[i] <= '0;
                reg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_WAIT; i++) begin
                if (kill_en && vld_q[i] && tag_q[i] == kill_tag)
                    vld_q[i] <= 1'b0;
                if (rel_en && rel_ptr == PTR_W'(i))
                    vld_q[i] <= 1'b0;
                if (add0_en && free0_ok && free0 == PTR_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    tag_q[i]  <= add_tag;
                    reg_q[i]  <= add0_reg;
                    slot_q[i] <= 1'b0;
                end
                if (add1_en && b_ok && b_ptr == PTR_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    tag_q[i]  <= add_tag;
                    reg_q[i]  <= add1_reg;
                    slot_q[i] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sb_pending_cnt.sv
// Per-tag count of source slots still waiting.
module sb_pending_cnt #(
    parameter int TAG_W = 3,
    localparam int NUM_TAGS = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic [1:0]       set_val,
    input  logic             kill_en,
    input  logic [TAG_W-1:0] kill_tag,
    input  logic             dec_en,
    input  logic [TAG_W-1:0] dec_tag,
    output logic             dec_last
);
    logic [1:0] cnt_q [NUM_TAGS];

    assign dec_last = (cnt_q[dec_tag] == 2'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TAGS; t++) cnt_q[t] <= 2'd0;
        end else begin
            for (int t = 0; t < NUM_TAGS; t++) begin
                if (set_en && set_tag == TAG_W'(t))
                    cnt_q[t] <= set_val;
                else if (kill_en && kill_tag == TAG_W'(t))
                    cnt_q[t] <= 2'd0;
                else if (dec_en && dec_tag == TAG_W'(t) && cnt_q[t] != 2'd0)
                    cnt_q[t] <= cnt_q[t] - 2'd1;
            end
        end
    end
endmodule

// File: rtl/wakeup_scoreboard.sv
module wakeup_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_PREGS = 16,
    parameter int IDX_W     = 5,
    parameter int TAG_W     = 3,
    parameter int NUM_WAIT  = 8,
    localparam int PTR_W    = (NUM_WAIT > 1) ? $clog2(NUM_WAIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid_i,
    input  logic [TAG_W-1:0] ins_tag_i,
    input  logic [IDX_W-1:0] ins_src0_i,
    input  logic             ins_src0_rdy_i,
    input  logic [IDX_W-1:0] ins_src1_i,
    input  logic             ins_src1_rdy_i,
    input  logic [IDX_W-1:0] ins_dst_i,
    input  logic             cmp_valid_i,
    input  logic [IDX_W-1:0] cmp_dst_i,
    input  logic             sq_valid_i,
    input  logic [TAG_W-1:0] sq_tag_i,
    output logic             busy_o,
    output logic             wk_valid_o,
    output logic [TAG_W-1:0] wk_tag_o,
    output logic             wk_slot_o,
    output logic             wk_last_o,
    output logic             ins_rdy_o,
    output logic [TAG_W-1:0] ins_rdy_tag_o,
    output logic             err_o
);
    localparam logic [IDX_W:0] PREG_LIM = (IDX_W + 1)'(NUM_PREGS);

    sb_state_e        state_q, state_d;
    logic [IDX_W-1:0] drn_reg_q;

    logic             dst_in, cmp_in, accept, emit;
    logic             rd0, rd1, need0, need1;
    logic             hit_any, hit_slot, chk_hit, dec_last;
    logic [PTR_W-1:0] hit_ptr;
    logic [TAG_W-1:0] hit_tag;

    assign dst_in = {1'b0, ins_dst_i} < PREG_LIM;
    assign cmp_in = {1'b0, cmp_dst_i} < PREG_LIM;
    assign busy_o = (state_q == SB_DRAIN);
    assign accept = cmp_valid_i && !busy_o && cmp_in;
    assign emit   = busy_o && hit_any;
    assign need0  = ins_valid_i && !ins_src0_rdy_i && !rd0;
    assign need1  = ins_valid_i && !ins_src1_rdy_i && !rd1;

    sb_ready_bits #(.NUM_PREGS(NUM_PREGS), .IDX_W(IDX_W)) u_ready (
        .clk(clk), .rst_n(rst_n),
        .set_en(accept), .set_idx(cmp_dst_i),
        .clr_en(ins_valid_i && dst_in), .clr_idx(ins_dst_i),
        .rd0_idx(ins_src0_i), .rd1_idx(ins_src1_i),
        .rd0(rd0), .rd1(rd1)
    );

    sb_waiter_table #(.NUM_WAIT(NUM_WAIT), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .add0_en(need0), .add1_en(need1), .add_tag(ins_tag_i),
        .add0_reg(ins_src0_i), .add1_reg(ins_src1_i),
        .kill_en(sq_valid_i), .kill_tag(sq_tag_i),
        .rel_en(emit), .rel_ptr(hit_ptr),
        .look_reg(drn_reg_q), .chk_reg(ins_dst_i),
        .hit_any(hit_any), .hit_ptr(hit_ptr), .hit_tag(hit_tag),
        .hit_slot(hit_slot), .chk_hit(chk_hit)
    );

    sb_pending_cnt #(.TAG_W(TAG_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_en(ins_valid_i), .set_tag(ins_tag_i),
        .set_val({1'b0, need0} + {1'b0, need1}),
        .kill_en(sq_valid_i), .kill_tag(sq_tag_i),
        .dec_en(emit), .dec_tag(hit_tag),
        .dec_last(dec_last)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_IDLE:  if (accept)   state_d = SB_DRAIN;
            SB_DRAIN: if (!hit_any) state_d = SB_IDLE;
            default:                state_d = SB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SB_IDLE;
            drn_reg_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) drn_reg_q <= cmp_dst_i;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_valid_o    <= 1'b0;
            wk_tag_o      <= '0;
            wk_slot_o     <= 1'b0;
            wk_last_o     <= 1'b0;
            ins_rdy_o     <= 1'b0;
            ins_rdy_tag_o <= '0;
            err_o         <= 1'b0;
        end else begin
            wk_valid_o    <= emit;
            wk_tag_o      <= hit_tag;
            wk_slot_o     <= hit_slot;
            wk_last_o     <= emit && dec_last;
            ins_rdy_o     <= ins_valid_i && !need0 && !need1;
            ins_rdy_tag_o <= ins_tag_i;
            err_o         <= ins_valid_i && dst_in && chk_hit;
        end
    end
endmodule

// File: rtl/wakeup_scoreboard_chk.sv
module sb_wakeup_chk #(
    parameter int NUM_PREGS = 16,
    parameter int IDX_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_valid_i,
    input logic [IDX_W-1:0] cmp_dst_i,
    input logic             ins_valid_i,
    input logic             busy_o,
    input logic             wk_valid_o,
    input logic             wk_last_o,
    input logic             ins_rdy_o,
    input logic             err_o
);
    localparam logic [IDX_W:0] LIM = (IDX_W + 1)'(NUM_PREGS);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && !busy_o && ({1'b0, cmp_dst_i} < LIM)) |=> busy_o);

    p_oor_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid_i && !busy_o && ({1'b0, cmp_dst_i} >= LIM)) |=> !busy_o);

    p_wake_in_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wk_valid_o |-> busy_o);

    p_no_wake_on_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !wk_valid_o);

    p_err_after_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(ins_valid_i));

    p_rdy_after_insert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_rdy_o |-> $past(ins_valid_i));

    p_last_with_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wk_last_o |-> wk_valid_o);
endmodule

bind wakeup_scoreboard sb_wakeup_chk #(.NUM_PREGS(NUM_PREGS), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmp_valid_i(cmp_valid_i), .cmp_dst_i(cmp_dst_i),
    .ins_valid_i(ins_valid_i), .busy_o(busy_o), .wk_valid_o(wk_valid_o),
    .wk_last_o(wk_last_o), .ins_rdy_o(ins_rdy_o), .err_o(err_o)
);

// File: tb/wakeup_scoreboard_tb_top.sv
`timescale 1ns/1ps
module wakeup_scoreboard_tb_top;
    localparam int NP = 16, IW = 5, TW = 3, NW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ins_valid = 1'b0, r0 = 1'b0, r1 = 1'b0;
    logic [TW-1:0] itag = '0, sqtag = '0;
    logic [IW-1:0] s0 = '0, s1 = '0, dst = '0, cdst = '0;
    logic cvalid = 1'b0, sqv = 1'b0;
    logic busy, wkv, wks, wkl, irdy, err;
    logic [TW-1:0] wkt, irtag;

    int errors = 0, checks = 0, wk_n = 0, bc = 0, base = 0;
    int lg_tag[16], lg_slot[16], lg_last[16];
    bit done = 1'b0;

    always #10 clk = ~clk;

    wakeup_scoreboard #(.NUM_PREGS(NP), .IDX_W(IW), .TAG_W(TW), .NUM_WAIT(NW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid), .ins_tag_i(itag),
        .ins_src0_i(s0), .ins_src0_rdy_i(r0), .ins_src1_i(s1), .ins_src1_rdy_i(r1),
        .ins_dst_i(dst), .cmp_valid_i(cvalid), .cmp_dst_i(cdst),
        .sq_valid_i(sqv), .sq_tag_i(sqtag), .busy_o(busy), .wk_valid_o(wkv),
        .wk_tag_o(wkt), .wk_slot_o(wks), .wk_last_o(wkl), .ins_rdy_o(irdy),
        .ins_rdy_tag_o(irtag), .err_o(err)
    );

    always @(negedge clk) begin
        if (rst_n && wkv) begin
            lg_tag[wk_n % 16]  = int'(wkt);
            lg_slot[wk_n % 16] = int'(wks);
            lg_last[wk_n % 16] = int'(wkl);
            wk_n = wk_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ins(input int tag, input int a, input bit ar, input int b,
                       input bit br, input int d);
        @(negedge clk);
        ins_valid = 1'b1; itag = TW'(tag);
        s0 = IW'(a); r0 = ar; s1 = IW'(b); r1 = br; dst = IW'(d);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic cmp(input int d);
        @(negedge clk);
        cvalid = 1'b1; cdst = IW'(d);
        @(negedge clk);
        cvalid = 1'b0;
        bc = 0;
        while (busy) begin bc++; @(negedge clk); end
    endtask

    task automatic chk_wk(input int k, input string req, input int t, input int s, input int l);
        chk(lg_tag[(base + k) % 16] == t, req, lg_tag[(base + k) % 16], t);
        chk(lg_slot[(base + k) % 16] == s, req, lg_slot[(base + k) % 16], s);
        chk(lg_last[(base + k) % 16] == l, req, lg_last[(base + k) % 16], l);
    endtask

    // tag[20:18] src0[17:13] rdy0[12] src1[11:7] rdy1[6] dst[5:1] exp_ready[0]
    localparam logic [20:0] VEC [6] = '{
        {3'd0, 5'd20, 1'b0, 5'd31, 1'b0, 5'd31, 1'b1},  // R6 untracked sources
        {3'd1, 5'd2,  1'b1, 5'd3,  1'b1, 5'd31, 1'b1},  // R10 flagged ready
        {3'd2, 5'd4,  1'b0, 5'd5,  1'b1, 5'd31, 1'b0},  // R1 R5 waits on 4
        {3'd3, 5'd16, 1'b0, 5'd15, 1'b1, 5'd31, 1'b1},  // R6 boundary index
        {3'd4, 5'd15, 1'b1, 5'd15, 1'b0, 5'd31, 1'b0},  // R5 slot 1 waits on 15
        {3'd5, 5'd6,  1'b0, 5'd6,  1'b0, 5'd31, 1'b0}   // R5 both slots on 6
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy", busy, 0);
        chk(!wkv, "R1 wk_valid", wkv, 0);
        chk(!irdy, "R1 ins_rdy", irdy, 0);
        chk(!err, "R1 err", err, 0);

        for (int v = 0; v < 6; v++) begin
            ins(int'(VEC[v][20:18]), int'(VEC[v][17:13]), VEC[v][12],
                int'(VEC[v][11:7]), VEC[v][6], int'(VEC[v][5:1]));
            chk(irdy == VEC[v][0], "R5/R6/R10 vector ready", irdy, int'(VEC[v][0]));
            chk(!err, "R3 vector err", err, 0);
            if (VEC[v][0]) chk(int'(irtag) == int'(VEC[v][20:18]), "R10 ready tag",
                                int'(irtag), int'(VEC[v][20:18]));
        end

        // R7 R8 R10: two waiters of tag 5 on register 6
        base = wk_n;
        cmp(6);
        chk(wk_n - base == 2, "R7 wake count", wk_n - base, 2);
        chk_wk(0, "R5 first wake", 5, 0, 0);
        chk_wk(1, "R10 last wake", 5, 1, 1);
        chk(bc == 3, "R8 busy length", bc, 3);

        // R4 R7: register 6 now ready, no waiter left
        ins(6, 6, 1'b0, 0, 1'b1, 31);
        chk(irdy == 1'b1, "R4 ready at insert", irdy, 1);
        base = wk_n;
        cmp(6);
        chk(wk_n - base == 0, "R4 no wake", wk_n - base, 0);
        chk(bc == 1, "R8 empty drain", bc, 1);

        // R9 squash tag 2 (waits on 4)
        @(negedge clk); sqv = 1'b1; sqtag = 3'd2;
        @(negedge clk); sqv = 1'b0;
        base = wk_n;
        cmp(4);
        chk(wk_n - base == 0, "R9 squashed wake", wk_n - base, 0);
        ins(2, 4, 1'b0, 0, 1'b1, 31);
        chk(irdy == 1'b1, "R7 ready bit set", irdy, 1);

        // R3 producer over a live waiter (tag 4 on 15)
        ins(7, 0, 1'b1, 0, 1'b1, 15);
        chk(err == 1'b1, "R3 err", err, 1);
        ins(0, 0, 1'b1, 0, 1'b1, 4);
        chk(err == 1'b0, "R3 no err", err, 0);
        // R2: register 4 cleared by the insert above
        ins(1, 4, 1'b0, 0, 1'b1, 31);
        chk(irdy == 1'b0, "R2 dest cleared", irdy, 0);

        // R8: completion held across a busy window
        base = wk_n;
        @(negedge clk); cvalid = 1'b1; cdst = 5'd15;
        @(negedge clk); cdst = 5'd4;
        while (busy) @(negedge clk);
        @(negedge clk); cvalid = 1'b0;
        while (busy) @(negedge clk);
        chk(wk_n - base == 2, "R8 held completion", wk_n - base, 2);
        chk_wk(0, "R8 first drain", 4, 1, 1);
        chk_wk(1, "R8 second drain", 1, 0, 1);

        // R6 untracked completion
        base = wk_n;
        @(negedge clk); cvalid = 1'b1; cdst = 5'd20;
        @(negedge clk); cvalid = 1'b0;
        chk(!busy, "R6 dropped completion", busy, 0);
        chk(wk_n - base == 0, "R6 no wake", wk_n - base, 0);

        // R11 insert racing completion of its source
        base = wk_n;
        @(negedge clk);
        ins_valid = 1'b1; itag = 3'd3; s0 = 5'd9; r0 = 1'b0; s1 = 5'd0; r1 = 1'b1;
        dst = 5'd31; cvalid = 1'b1; cdst = 5'd9;
        @(negedge clk);
        ins_valid = 1'b0; cvalid = 1'b0;
        chk(irdy == 1'b0, "R11 waits", irdy, 0);
        while (busy) @(negedge clk);
        chk(wk_n - base == 1, "R11 wake count", wk_n - base, 1);
        chk_wk(0, "R11 wake", 3, 0, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule